// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside the instruction sequencer of an 8-bit CPU with a 16-bit program counter and stack pointer. When the CPU pulses `boundary` between instructions, the block decides whether a pending non-maskable or maskable request may be taken. If one is taken, it runs the response sequence one T-state per clock. It drives the flag-clear strobes in the acceptance cycle. It then issues the stack pushes, the acknowledge cycle and the vector-table reads at fixed T-states. It finishes with a new PC and SP, and a done pulse that carries the total T-state count.

The clock cycle in which `boundary` causes acceptance is T0. The following cycles are T1, T2 and so on. Memory accesses are single-cycle strobes. Read data must be present on `dataIn` in the same cycle as `memRd` or `ackCycle`. In mode 0 the block does not execute anything: it hands each acknowledged bus byte to the decoder and waits for the decoder to report whether a prefix is still pending.

Top module: `intseq_top`

## Requirements
- R1: A request is taken only in a cycle with `boundary` high, while no sequence is running, and with `busy`, `prefixPending` and `chainedPrefix` all low. Otherwise no clear strobe is issued and no sequence starts.
- R2: A maskable request also needs `iff1` high. Taking it pulses `iff1Clr` and `iff2Clr` in T0.
- R3: A non-maskable request is taken whatever the value of `iff1`. Taking it pulses `iff1Clr` in T0 with `iff2Clr` low. When both requests are present, the non-maskable one wins.
- R4: If `halted` is high in T0, `haltClr` pulses in T0, and the pushed PC is `pcIn`+1 (modulo 2^16) instead of `pcIn`.
- R5: Non-maskable response: at T5 write PC[15:8] to SP-1, and at T8 write PC[7:0] to SP-2. At T11 load PC with 0x0066, load SP with SP-2, and pulse done with count 11.
- R6: `rInc` pulses in T0 for a non-maskable request and for maskable modes 1 and 2. `intMode` 0, 1 and 2 select modes 0, 1 and 2, and the value 3 behaves as mode 1.
- R7: `pvClr` pulses in T0 exactly when a maskable request is taken while `pvFromIff2` is high.
- R8: Mode 1: the PC high byte is written to SP-1 at T7 and the low byte to SP-2 at T10. At T13 PC loads 0x0038, SP loads SP-2, and done reports 13.
- R9: Mode 2: `ackCycle` is high at T7 and `dataIn` is captured as the vector. The pushes are at T7 (high byte) and T10 (low byte). At T13 the new PC low byte is read from {I, vector}. At T16 the high byte is read from that address plus one, with 16-bit wrap. At T19 PC and SP load and done reports 19.
- R10: Mode 0: each fetch lasts six T-states, and in its sixth `ackCycle`, `opValid` and `rInc` are high with `opByte` equal to `dataIn`. In the next cycle a high `prefixPending` starts another fetch. Otherwise done pulses with count 6 times the number of fetches. Mode 0 makes no memory access and loads neither PC nor SP.
- R11: Requests and boundary strobes arriving while a sequence runs, including in its done cycle, are ignored. Values on `pcIn`, `spIn`, `iReg` and `halted` after T0 do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | One-cycle instruction boundary strobe |
| nmiReq | input | 1 | Non-maskable request |
| intReq | input | 1 | Maskable request |
| iff1 | input | 1 | Interrupt enable flag 1 |
| busy | input | 1 | An instruction is in progress |
| prefixPending | input | 1 | A prefix byte awaits its opcode |
| chainedPrefix | input | 1 | The last step was a chained prefix byte |
| pvFromIff2 | input | 1 | The last instruction copied IFF2 into P/V |
| halted | input | 1 | The CPU is halted |
| intMode | input | 2 | Maskable mode select |
| iReg | input | 8 | Interrupt page register |
| pcIn | input | 16 | Current PC |
| spIn | input | 16 | Current SP |
| dataIn | input | 8 | Read and acknowledge data |
| iff1Clr | output | 1 | Clear IFF1 |
| iff2Clr | output | 1 | Clear IFF2 |
| pvClr | output | 1 | Clear the parity/overflow flag |
| haltClr | output | 1 | Leave the halt state |
| rInc | output | 1 | Increment the refresh register |
| ackCycle | output | 1 | Interrupt acknowledge bus cycle |
| opValid | output | 1 | Mode 0 byte valid for the decoder |
| opByte | output | 8 | Mode 0 byte for the decoder |
| memWr | output | 1 | Memory write strobe |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| pcLoad | output | 1 | Load PC |
| pcOut | output | 16 | New PC |
| spLoad | output | 1 | Load SP |
| spOut | output | 16 | New SP |
| done | output | 1 | Response finished |
| tCount | output | 8 | Total T-states of the response, valid with done |

## Verification
The assertions assume that memory and the acknowledge cycle return data in the same cycle as the strobe. They also assume that `prefixPending` is driven only by the decoder, and that status inputs hold their values in any cycle where `boundary` is high. The bench meets this by computing `dataIn` combinationally from the strobe and address with a fixed arithmetic byte function. It drives every input half a cycle away from the rising edge. It raises `prefixPending` during a mode 0 sequence only in the cycle after a decoder byte. During every running sequence it deliberately holds `boundary` and both requests high, and it scrambles `pcIn`, `spIn`, `iReg` and `halted`.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  typedef enum logic [1:0] {
    K_NMI = 2'd0,
    K_IM0 = 2'd1,
    K_IM1 = 2'd2,
    K_IM2 = 2'd3
  } kindT;

  typedef struct packed {
    logic capture;
    kindT kind;
    logic wrHi;
    logic wrLo;
    logic ackVec;
    logic rdLo;
    logic rdHi;
    logic m0Fetch;
    logic finish;
  } stbT;

  // T-state positions of each event, counted from acceptance (T0)
  localparam int NMI_WR_HI = 5;
  localparam int NMI_END   = 11;
  localparam int RST_WR_HI = 7;
  localparam int IM1_END   = 13;
  localparam int PUSH_GAP  = 3;
  localparam int IM2_VEC   = 7;
  localparam int IM2_RD_LO = 13;
  localparam int IM2_RD_HI = 16;
  localparam int IM2_END   = 19;
  localparam int M0_FETCH  = 6;
  localparam int M0_CHECK  = M0_FETCH + 1;

endpackage

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
  import intseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             nmiReq,
  input  logic             intReq,
  input  logic             iff1,
  input  logic             busy,
  input  logic             prefixPending,
  input  logic             chainedPrefix,
  input  logic             pvFromIff2,
  input  logic             halted,
  input  logic [1:0]       intMode,
  output logic             iff1Clr,
  output logic             iff2Clr,
  output logic             pvClr,
  output logic             haltClr,
  output logic             rInc,
  output logic             ackCycle,
  output logic             opValid,
  output logic             done,
  output logic [CNT_W-1:0] tCount,
  output stbT              stb
);

  logic             running;
  kindT             kind, newKind;
  logic [CNT_W-1:0] tPh, tot;
  logic             blocked, takeNmi, takeInt, take;
  logic             m0Check, restart;

  function automatic logic atT(input logic run, input logic [CNT_W-1:0] ph, input int n);
    return run && (ph == CNT_W'(n));
  endfunction

  assign blocked = running | busy | prefixPending | chainedPrefix;
  assign takeNmi = boundary & nmiReq & ~blocked;
  assign takeInt = boundary & intReq & iff1 & ~nmiReq & ~blocked;
  assign take    = takeNmi | takeInt;

  always_comb begin
    if (takeNmi)              newKind = K_NMI;
    else if (intMode == 2'd0) newKind = K_IM0;
    else if (intMode == 2'd2) newKind = K_IM2;
    else                      newKind = K_IM1;
  end

  assign m0Check = (kind == K_IM0) && atT(running, tPh, M0_CHECK);
  assign restart = m0Check && prefixPending;

  always_comb begin
    stb         = '0;
    stb.capture = take;
    stb.kind    = kind;
    unique case (kind)
      K_NMI: begin
        stb.wrHi   = atT(running, tPh, NMI_WR_HI);
        stb.wrLo   = atT(running, tPh, NMI_WR_HI + PUSH_GAP);
        stb.finish = atT(running, tPh, NMI_END);
      end
      K_IM1: begin
        stb.wrHi   = atT(running, tPh, RST_WR_HI);
        stb.wrLo   = atT(running, tPh, RST_WR_HI + PUSH_GAP);
        stb.finish = atT(running, tPh, IM1_END);
      end
      K_IM2: begin
        stb.ackVec = atT(running, tPh, IM2_VEC);
        stb.wrHi   = atT(running, tPh, RST_WR_HI);
        stb.wrLo   = atT(running, tPh, RST_WR_HI + PUSH_GAP);
        stb.rdLo   = atT(running, tPh, IM2_RD_LO);
        stb.rdHi   = atT(running, tPh, IM2_RD_HI);
        stb.finish = atT(running, tPh, IM2_END);
      end
      default: begin
        stb.m0Fetch = atT(running, tPh, M0_FETCH);
        stb.finish  = m0Check && !prefixPending;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      kind    <= K_NMI;
      tPh     <= '0;
      tot     <= '0;
    end else if (take) begin
      running <= 1'b1;
      kind    <= newKind;
      tPh     <= CNT_W'(1);
      tot     <= CNT_W'(1);
    end else if (running) begin
      if (stb.finish) begin
        running <= 1'b0;
      end else if (restart) begin
        tPh <= CNT_W'(1);
      end else begin
        tPh <= tPh + CNT_W'(1);
        tot <= tot + CNT_W'(1);
      end
    end
  end

  assign iff1Clr  = take;
  assign iff2Clr  = takeInt;
  assign pvClr    = takeInt & pvFromIff2;
  assign haltClr  = take & halted;
  assign rInc     = (take && newKind != K_IM0) || stb.m0Fetch;
  assign ackCycle = stb.ackVec | stb.m0Fetch;
  assign opValid  = stb.m0Fetch;
  assign done     = stb.finish;
  assign tCount   = (kind == K_IM0) ? tot - CNT_W'(1) : tot;

  // R1: a busy, prefixed or chained step never lets a request through
  a_r1_gated: assert property (@(posedge clk) disable iff (!rstN)
    (busy || prefixPending || chainedPrefix) |-> !iff1Clr);
  // R2: a maskable acceptance requires IFF1
  a_r2_needs_iff1: assert property (@(posedge clk) disable iff (!rstN)
    iff2Clr |-> (iff1 && intReq && iff1Clr));
  // R3: an NMI acceptance leaves IFF2 alone
  a_r3_nmi_keeps_iff2: assert property (@(posedge clk) disable iff (!rstN)
    (iff1Clr && nmiReq) |-> !iff2Clr);
  // R7: the P/V clear only goes with a maskable acceptance
  a_r7_pv_with_int: assert property (@(posedge clk) disable iff (!rstN)
    pvClr |-> iff2Clr);
  // R6: mode 0 acceptance does not bump R in T0
  a_r6_no_rinc_m0: assert property (@(posedge clk) disable iff (!rstN)
    (iff2Clr && intMode == 2'd0) |-> !rInc);
  // R11: no second acceptance while a response is in progress
  a_r11_no_reaccept: assert property (@(posedge clk) disable iff (!rstN)
    iff1Clr |=> !iff1Clr);
  // R5: the NMI response always reports 11 T-states
  a_r5_nmi_len: assert property (@(posedge clk) disable iff (!rstN)
    (done && kind == K_NMI) |-> tCount == CNT_W'(NMI_END));

endmodule

// File: rtl/intseq_dp.sv
module intseq_dp
  import intseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  stbT             stb,
  input  logic [2*DW-1:0] pcIn,
  input  logic [2*DW-1:0] spIn,
  input  logic [DW-1:0]   iReg,
  input  logic            halted,
  input  logic [DW-1:0]   dataIn,
  output logic            memWr,
  output logic            memRd,
  output logic [2*DW-1:0] memAddr,
  output logic [DW-1:0]   memWdata,
  output logic            pcLoad,
  output logic [2*DW-1:0] pcOut,
  output logic            spLoad,
  output logic [2*DW-1:0] spOut,
  output logic [DW-1:0]   opByte
);

  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] NMI_PC = AW'(16'h0066);
  localparam logic [AW-1:0] RST_PC = AW'(16'h0038);

  logic [AW-1:0] pcSave, spSave, tblAddr;
  logic [DW-1:0] iSave, vecSave, loSave, hiSave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcSave  <= '0;
      spSave  <= '0;
      iSave   <= '0;
      vecSave <= '0;
      loSave  <= '0;
      hiSave  <= '0;
    end else begin
      if (stb.capture) begin
        pcSave <= pcIn + {{(AW-1){1'b0}}, halted};
        spSave <= spIn;
        iSave  <= iReg;
      end
      if (stb.ackVec) vecSave <= dataIn;
      if (stb.rdLo)   loSave  <= dataIn;
      if (stb.rdHi)   hiSave  <= dataIn;
    end
  end

  assign tblAddr = {iSave, vecSave};

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    if (stb.wrHi) begin
      memAddr  = spSave - AW'(1);
      memWdata = pcSave[AW-1:DW];
    end else if (stb.wrLo) begin
      memAddr  = spSave - AW'(2);
      memWdata = pcSave[DW-1:0];
    end else if (stb.rdLo) begin
      memAddr = tblAddr;
    end else if (stb.rdHi) begin
      memAddr = tblAddr + AW'(1);
    end
  end

  assign memWr  = stb.wrHi | stb.wrLo;
  assign memRd  = stb.rdLo | stb.rdHi;
  assign pcLoad = stb.finish && stb.kind != K_IM0;
  assign spLoad = pcLoad;
  assign spOut  = spSave - AW'(2);
  assign opByte = stb.m0Fetch ? dataIn : '0;

  always_comb begin
    unique case (stb.kind)
      K_NMI:   pcOut = NMI_PC;
      K_IM1:   pcOut = RST_PC;
      K_IM2:   pcOut = {hiSave, loSave};
      default: pcOut = '0;
    endcase
  end

  // R5: the low-byte push lands one byte below the high-byte push
  a_r5_push_order: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrHi |-> ##3 (memWr && memAddr == $past(memAddr, 3) - AW'(1)));
  // R9: the second table read follows the first by one address
  a_r9_table_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdHi |-> (memAddr == $past(memAddr, 3) + AW'(1)));
  // R10: mode 0 never touches memory or the PC
  a_r10_m0_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == K_IM0) |-> !(memWr || memRd || pcLoad));
  // R8: reads and writes never share a cycle
  a_r8_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr && memRd));

endmodule

// File: rtl/intseq_top.sv
module intseq_top
  import intseq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             nmiReq,
  input  logic             intReq,
  input  logic             iff1,
  input  logic             busy,
  input  logic             prefixPending,
  input  logic             chainedPrefix,
  input  logic             pvFromIff2,
  input  logic             halted,
  input  logic [1:0]       intMode,
  input  logic [DW-1:0]    iReg,
  input  logic [2*DW-1:0]  pcIn,
  input  logic [2*DW-1:0]  spIn,
  input  logic [DW-1:0]    dataIn,
  output logic             iff1Clr,
  output logic             iff2Clr,
  output logic             pvClr,
  output logic             haltClr,
  output logic             rInc,
  output logic             ackCycle,
  output logic             opValid,
  output logic [DW-1:0]    opByte,
  output logic             memWr,
  output logic             memRd,
  output logic [2*DW-1:0]  memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             pcLoad,
  output logic [2*DW-1:0]  pcOut,
  output logic             spLoad,
  output logic [2*DW-1:0]  spOut,
  output logic             done,
  output logic [CNT_W-1:0] tCount
);

  stbT stb;

  intseq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiReq(nmiReq),
    .intReq(intReq), .iff1(iff1), .busy(busy), .prefixPending(prefixPending),
    .chainedPrefix(chainedPrefix), .pvFromIff2(pvFromIff2), .halted(halted),
    .intMode(intMode), .iff1Clr(iff1Clr), .iff2Clr(iff2Clr), .pvClr(pvClr),
    .haltClr(haltClr), .rInc(rInc), .ackCycle(ackCycle), .opValid(opValid),
    .done(done), .tCount(tCount), .stb(stb)
  );

  intseq_dp #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pcIn(pcIn), .spIn(spIn),
    .iReg(iReg), .halted(halted), .dataIn(dataIn), .memWr(memWr),
    .memRd(memRd), .memAddr(memAddr), .memWdata(memWdata), .pcLoad(pcLoad),
    .pcOut(pcOut), .spLoad(spLoad), .spOut(spOut), .opByte(opByte)
  );

endmodule

// File: tb/sim_intseq_top.sv
module sim_intseq_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        boundary, nmiReq, intReq, iff1, busy, prefixPending;
  logic        chainedPrefix, pvFromIff2, halted;
  logic [1:0]  intMode;
  logic [7:0]  iReg, dataIn, busByte;
  logic [15:0] pcIn, spIn;
  logic        iff1Clr, iff2Clr, pvClr, haltClr, rInc, ackCycle, opValid;
  logic [7:0]  opByte, memWdata, tCount;
  logic        memWr, memRd, pcLoad, spLoad, done;
  logic [15:0] memAddr, pcOut, spOut;

  int nChk = 0;
  int nBad = 0;
  int curT = 0;

  always #5 clk = ~clk;

  intseq_top u0 (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiReq(nmiReq),
    .intReq(intReq), .iff1(iff1), .busy(busy), .prefixPending(prefixPending),
    .chainedPrefix(chainedPrefix), .pvFromIff2(pvFromIff2), .halted(halted),
    .intMode(intMode), .iReg(iReg), .pcIn(pcIn), .spIn(spIn), .dataIn(dataIn),
    .iff1Clr(iff1Clr), .iff2Clr(iff2Clr), .pvClr(pvClr), .haltClr(haltClr),
    .rInc(rInc), .ackCycle(ackCycle), .opValid(opValid), .opByte(opByte),
    .memWr(memWr), .memRd(memRd), .memAddr(memAddr), .memWdata(memWdata),
    .pcLoad(pcLoad), .pcOut(pcOut), .spLoad(spLoad), .spOut(spOut),
    .done(done), .tCount(tCount)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  always_comb begin
    if (memRd)         dataIn = memByte(memAddr);
    else if (ackCycle) dataIn = busByte;
    else               dataIn = 8'h00;
  end

  function automatic logic [95:0] packV(
      input logic wr, input logic rd, input logic [15:0] addr, input logic [7:0] wd,
      input logic ack, input logic opv, input logic [7:0] opb,
      input logic pcl, input logic [15:0] pco, input logic spl, input logic [15:0] spo,
      input logic dn, input logic [7:0] cnt,
      input logic ri, input logic c1, input logic c2, input logic pv, input logic hc);
    return {12'h0, wr, rd, (wr | rd) ? addr : 16'h0, wr ? wd : 8'h0, ack, opv,
            opv ? opb : 8'h0, pcl, pcl ? pco : 16'h0, spl, spl ? spo : 16'h0,
            dn, dn ? cnt : 8'h0, ri, c1, c2, pv, hc};
  endfunction

  function automatic logic [95:0] obsNow();
    return packV(memWr, memRd, memAddr, memWdata, ackCycle, opValid, opByte,
                 pcLoad, pcOut, spLoad, spOut, done, tCount,
                 rInc, iff1Clr, iff2Clr, pvClr, haltClr);
  endfunction

  task automatic check(input string tag, input logic [95:0] e);
    logic [95:0] o;
    o = obsNow();
    nChk++;
    if (o !== e) begin
      nBad++;
      $display("FAIL %s T%0d act=%h exp=%h", tag, curT, o, e);
    end
  endtask

  task automatic idleInputs();
    boundary = 0; nmiReq = 0; intReq = 0; iff1 = 0; busy = 0;
    prefixPending = 0; chainedPrefix = 0; pvFromIff2 = 0; halted = 0;
    intMode = 0; iReg = 0; pcIn = 0; spIn = 0; busByte = 0;
  endtask

  // R1 R2: a request that must not be taken leaves every output quiet
  task automatic gateTest(input string tag, input logic bsy, input logic pre,
                          input logic chn, input logic ie, input logic nm,
                          input logic it, input logic bnd);
    @(negedge clk);
    idleInputs();
    busy = bsy; prefixPending = pre; chainedPrefix = chn; iff1 = ie;
    nmiReq = nm; intReq = it; boundary = bnd; halted = 1; pvFromIff2 = 1;
    intMode = 2'd2; pcIn = 16'h4321; spIn = 16'h9000;
    curT = 0;
    #1 check(tag, '0);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      boundary = 0; busy = 0; prefixPending = 0; chainedPrefix = 0;
      curT = k;
      #1 check(tag, '0);
    end
  endtask

  task automatic runSeq(input logic isNmi, input int mode, input logic hl,
                        input logic pvf, input logic [15:0] pc, input logic [15:0] sp,
                        input logic [7:0] iv, input logic [7:0] vec,
                        input int nF, input logic both);
    int em, endT, hiW;
    logic [15:0] pcP, ta, newPc;
    logic [95:0] e;
    string tag;
    em  = (mode == 3) ? 1 : mode;
    pcP = pc + {15'h0, hl};
    @(negedge clk);
    idleInputs();
    boundary = 1; nmiReq = isNmi; intReq = !isNmi || both;
    iff1 = isNmi ? hl : 1'b1; halted = hl; pvFromIff2 = pvf;
    intMode = 2'(mode); iReg = iv; pcIn = pc; spIn = sp; busByte = vec;
    curT = 0;
    // R2 R3 R4 R6 R7: acceptance strobes in T0
    #1 check(isNmi ? "R3 R4 R6 acceptance" : "R2 R4 R6 R7 acceptance",
             packV(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                   isNmi || em != 0, 1, !isNmi, !isNmi && pvf, hl));
    if (!isNmi && em == 0) begin
      for (int f = 1; f <= nF; f++) begin
        for (int t = 1; t <= 7; t++) begin
          @(negedge clk);
          boundary = 1; nmiReq = 1; intReq = 1; halted = 1;   // R11 noise
          pcIn = 16'hDEAD; spIn = 16'hBEEF;
          busByte = vec + 8'(f);
          prefixPending = (t == 7) && (f < nF);
          curT = t;
          e = '0;
          if (t == 6)
            e = packV(0, 0, 0, 0, 1, 1, vec + 8'(f), 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
          if (t == 7 && f == nF)
            e = packV(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'(6 * nF), 0, 0, 0, 0, 0);
          #1 check("R10 R11 mode0", e);
        end
      end
    end else begin
      endT = isNmi ? 11 : (em == 1 ? 13 : 19);
      hiW  = isNmi ? 5 : 7;
      tag  = isNmi ? "R5 R11 nmi" : (em == 1 ? "R8 R11 mode1" : "R9 R11 mode2");
      ta   = {iv, vec};
      if (isNmi)        newPc = 16'h0066;
      else if (em == 1) newPc = 16'h0038;
      else              newPc = {memByte(ta + 16'h1), memByte(ta)};
      for (int t = 1; t <= endT; t++) begin
        @(negedge clk);
        boundary = 1; nmiReq = 1; intReq = 1; halted = 1;   // R11 noise
        pcIn = 16'hDEAD; spIn = 16'hBEEF; iReg = 8'h11;
        curT = t;
        e = '0;
        if (t == hiW)
          e = packV(1, 0, sp - 16'h1, pcP[15:8], 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        if (t == hiW + 3)
          e = packV(1, 0, sp - 16'h2, pcP[7:0], 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        if (!isNmi && em == 2) begin
          if (t == 7) e[10] = 1'b0;
          if (t == 7) e = e | packV(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
          if (t == 13)
            e = packV(0, 1, ta, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
          if (t == 16)
            e = packV(0, 1, ta + 16'h1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
        if (t == endT)
          e = packV(0, 0, 0, 0, 0, 0, 0, 1, newPc, 1, sp - 16'h2, 1, 8'(endT),
                    0, 0, 0, 0, 0);
        #1 check(tag, e);
      end
    end
    @(negedge clk);
    idleInputs();
    curT = 99;
    #1 check("R11 idle after done", '0);
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    curT = 0;
    #1 check("R1 reset state", '0);
    rstN = 1;

    gateTest("R1 busy blocks nmi",        1, 0, 0, 1, 1, 1, 1);
    gateTest("R1 prefix blocks int",      0, 1, 0, 1, 0, 1, 1);
    gateTest("R1 chained blocks nmi",     0, 0, 1, 1, 1, 0, 1);
    gateTest("R1 no boundary",            0, 0, 0, 1, 1, 1, 0);
    gateTest("R2 int needs iff1",         0, 0, 0, 0, 0, 1, 1);

    for (int n = 0; n < 2; n++)
      for (int m = 0; m < 4; m++)
        for (int h = 0; h < 2; h++)
          for (int p = 0; p < 2; p++)
            for (int v = 0; v < 2; v++) begin
              if (v == 0)
                runSeq(n[0], m, h[0], p[0], 16'h1234, 16'h8000, 8'h3A, 8'h7E,
                       1 + ((h * 2 + p) % 3), v[0]);
              else
                runSeq(n[0], m, h[0], p[0], 16'hFFFF, 16'h0001, 8'hFF, 8'hFF,
                       1 + ((h * 2 + p + 1) % 3), v[0]);
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule